// File: doc/BRIEF.md
# I2C Bus Monitor

This block listens to the SCL and SDA lines of an I2C bus and never drives SDA. It synchronises both lines into the local clock and detects START, repeated START and STOP conditions. It shifts in each byte most significant bit first and samples the acknowledge bit on the ninth clock. Each completed byte goes into a single receive word, together with flags that mark whether it was the first byte after a START, the first byte after a repeated START, or a byte that was not acknowledged.

The host sees four indications: a ready flag for an unread word, a sticky overflow flag, an active flag while a transfer is under way, and an idle flag latched at the end of a transfer. The host consumes a word by pulsing a read strobe. If the host is too slow, two outcomes are possible. With stretching disabled, the late byte is dropped and overflow is raised. With stretching enabled, the monitor holds that byte and pulls SCL low after its acknowledge bit until the host reads.

Top module: `i2c_bus_sniffer`

## Requirements
- R1: After reset, ready, overflow, active, idle and the SCL hold output are all low, and the receive word is zero.
- R2: The first byte after a START from an idle bus has bit 8 of the receive word set and bit 9 clear.
- R3: The first byte after a START seen while a transfer is already active (a repeated START) has bit 9 set and bit 8 clear.
- R4: Bits 7:0 of the receive word hold the byte, with the first bit on the bus in bit 7. Bytes that are not the first after a START or repeated START have bits 8 and 9 clear.
- R5: Bit 10 of the receive word holds the SDA level sampled on the ninth SCL rise of the byte: 1 means NACK, 0 means ACK.
- R6: Ready rises when a byte is captured and falls only on a read strobe. A read strobe while ready is low changes nothing.
- R7: With stretching disabled, a byte that completes while ready is still high is discarded, the receive word keeps its old value, and overflow is set and stays set.
- R8: A pulse on the overflow-clear input clears overflow. If an overflow occurs in the same cycle, the set wins.
- R9: Active rises after a START and falls after a STOP. Idle is set by a STOP and cleared by a START. The two are never high together.
- R10: With stretching enabled, a byte that completes while ready is high is held back, and SCL is held low once it is seen low after that byte's acknowledge bit. A read then loads the held byte, keeps ready high and releases SCL, and overflow does not occur.
- R11: With the monitor disabled, no byte is captured, active stays low and SCL is never held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en_i | input | 1 | Monitor enable |
| stretch_en_i | input | 1 | Allows holding SCL low when the host falls behind |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| rd_ack_i | input | 1 | Host read strobe; consumes the receive word |
| ovf_clr_i | input | 1 | Write-one pulse that clears overflow |
| scl_hold_o | output | 1 | When high, the pad pulls SCL low |
| rx_word_o | output | 11 | Byte [7:0], after-START [8], after-repeated-START [9], NACK [10] |
| ready_o | output | 1 | Unread word present |
| overflow_o | output | 1 | Sticky: a byte was lost |
| active_o | output | 1 | Transfer in progress |
| idle_o | output | 1 | Latched at STOP, cleared at START |

## Verification
The bound checker checks on every cycle the relations between the host-side flags. It checks that active and idle never coincide, that overflow stays set until cleared, and that it cannot rise while stretching is enabled. It also checks that ready falls only after a read strobe, that an SCL hold always has an unread word behind it, and that disabling the monitor drops the hold. The scenarios are needed for everything that depends on decoding the bus waveform. That covers byte values and bit order, the START, repeated-START and NACK flags, and dropping the late byte on overflow. It also covers the order in which held bytes are delivered while SCL is stretched, and the absence of capture while the monitor is disabled.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

    // Layout decoded by the host: data low, then framing flags above it.
    typedef struct packed {
        logic              nack;
        logic              rstart;
        logic              start;
        logic [BYTE_W-1:0] data;
    } rx_word_t;

    localparam int unsigned WORD_W = $bits(rx_word_t);

endpackage

// File: rtl/sniff_sync.sv
module sniff_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d_i,
    output logic [LINES-1:0] q_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d_i[g]};
        end

        // Bus lines idle high, so the chain resets to ones.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign q_o[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/sniff_cond.sv
module sniff_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s_i;
        prev_d.sda = sda_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // SDA may only move with SCL high for a bus condition.
    assign start_o    = prev_q.scl && scl_s_i && prev_q.sda && !sda_s_i;
    assign stop_o     = prev_q.scl && scl_s_i && !prev_q.sda && sda_s_i;
    assign scl_rise_o = !prev_q.scl && scl_s_i;

endmodule

// File: rtl/sniff_shifter.sv
module sniff_shifter
    import sniff_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_i,
    input  logic     start_i,
    input  logic     stop_i,
    input  logic     scl_rise_i,
    input  logic     sda_s_i,
    output logic     in_frame_o,
    output logic     byte_vld_o,
    output rx_word_t byte_o
);

    typedef struct packed {
        logic              in_frame;
        logic              tag_start;
        logic              tag_rstart;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              vld;
        rx_word_t          word;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (!en_i) begin
            d.in_frame   = 1'b0;
            d.tag_start  = 1'b0;
            d.tag_rstart = 1'b0;
            d.cnt        = '0;
        end else if (start_i) begin
            d.tag_start  = !q.in_frame;
            d.tag_rstart = q.in_frame;
            d.in_frame   = 1'b1;
            d.cnt        = '0;
        end else if (stop_i) begin
            d.in_frame   = 1'b0;
            d.tag_start  = 1'b0;
            d.tag_rstart = 1'b0;
            d.cnt        = '0;
        end else if (scl_rise_i && q.in_frame) begin
            if (q.cnt == CNT_W'(BYTE_W)) begin
                // Ninth clock: acknowledge slot closes the byte.
                d.vld         = 1'b1;
                d.word.data   = q.shreg;
                d.word.start  = q.tag_start;
                d.word.rstart = q.tag_rstart;
                d.word.nack   = sda_s_i;
                d.tag_start   = 1'b0;
                d.tag_rstart  = 1'b0;
                d.cnt         = '0;
            end else begin
                d.shreg = {q.shreg[BYTE_W-2:0], sda_s_i};
                d.cnt   = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_frame_o = q.in_frame;
    assign byte_vld_o = q.vld;
    assign byte_o     = q.word;

endmodule

// File: rtl/i2c_bus_sniffer.sv
module i2c_bus_sniffer
    import sniff_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_en_i,
    input  logic              stretch_en_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              rd_ack_i,
    input  logic              ovf_clr_i,
    output logic              scl_hold_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              ready_o,
    output logic              overflow_o,
    output logic              active_o,
    output logic              idle_o
);

    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] lines_s;
    logic               scl_s, sda_s;
    logic               start_c, stop_c, scl_rise_c;
    logic               start_g, stop_g;
    logic               byte_vld;
    rx_word_t           byte_w;
    logic               in_frame;

    sniff_sync #(.STAGES(SYNC_STAGES), .LINES(N_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    sniff_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .start_o    (start_c),
        .stop_o     (stop_c),
        .scl_rise_o (scl_rise_c)
    );

    assign start_g = start_c && mon_en_i;
    assign stop_g  = stop_c && mon_en_i;

    sniff_shifter u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (mon_en_i),
        .start_i    (start_c),
        .stop_i     (stop_c),
        .scl_rise_i (scl_rise_c),
        .sda_s_i    (sda_s),
        .in_frame_o (in_frame),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_w)
    );

    typedef struct packed {
        rx_word_t rx;
        logic     ready;
        rx_word_t pend;
        logic     pend_vld;
        logic     ovf;
        logic     idle;
        logic     hold;
    } host_t;

    host_t d, q;
    logic  take, ovf_set;

    always_comb begin
        d       = q;
        take    = rd_ack_i && q.ready;
        ovf_set = 1'b0;

        if (take) begin
            if (q.pend_vld) begin
                d.rx       = q.pend;
                d.pend_vld = 1'b0;
            end else begin
                d.ready = 1'b0;
            end
        end

        if (byte_vld) begin
            if (!d.ready) begin
                d.rx    = byte_w;
                d.ready = 1'b1;
            end else if (stretch_en_i && !d.pend_vld) begin
                d.pend     = byte_w;
                d.pend_vld = 1'b1;
            end else begin
                ovf_set = 1'b1;
            end
        end

        if (ovf_clr_i) d.ovf = 1'b0;
        if (ovf_set)   d.ovf = 1'b1;

        if (!mon_en_i) d.pend_vld = 1'b0;

        if (stop_g)       d.idle = 1'b1;
        else if (start_g) d.idle = 1'b0;

        // Grab SCL only once it is low, then keep it until the held byte moves up.
        d.hold = mon_en_i && stretch_en_i && d.pend_vld && (q.hold || !scl_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scl_hold_o = q.hold;
    assign rx_word_o  = q.rx;
    assign ready_o    = q.ready;
    assign overflow_o = q.ovf;
    assign active_o   = in_frame;
    assign idle_o     = q.idle;

endmodule

// File: rtl/sniff_checker.sv
module sniff_checker (
    input logic clk,
    input logic rst_n,
    input logic mon_en_i,
    input logic stretch_en_i,
    input logic rd_ack_i,
    input logic ovf_clr_i,
    input logic scl_hold_o,
    input logic ready_o,
    input logic overflow_o,
    input logic active_o,
    input logic idle_o
);

    // R6
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(rd_ack_i));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !ovf_clr_i) |=> overflow_o);

    // R9
    act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(active_o && idle_o));

    // R10
    hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold_o |-> ready_o);

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stretch_en_i) |-> !$rose(overflow_o));

    // R11
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_i |=> !scl_hold_o);

endmodule

bind i2c_bus_sniffer sniff_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mon_en_i     (mon_en_i),
    .stretch_en_i (stretch_en_i),
    .rd_ack_i     (rd_ack_i),
    .ovf_clr_i    (ovf_clr_i),
    .scl_hold_o   (scl_hold_o),
    .ready_o      (ready_o),
    .overflow_o   (overflow_o),
    .active_o     (active_o),
    .idle_o       (idle_o)
);

// File: tb/i2c_bus_sniffer_tb.sv
`timescale 1ns/1ps
module i2c_bus_sniffer_tb;
    import sniff_pkg::*;

    localparam int H = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic mon_en = 1'b0, stretch_en = 1'b0;
    logic rd_mon = 1'b0, rd_force = 1'b0, ovf_clr = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_hold, ready, overflow, active, idle;
    logic [WORD_W-1:0] rx_word;
    logic scl_line, rd_ack;

    assign scl_line = m_scl & ~scl_hold;
    assign rd_ack   = rd_mon | rd_force;

    i2c_bus_sniffer u_dut (
        .clk (clk), .rst_n (rst_n), .mon_en_i (mon_en), .stretch_en_i (stretch_en),
        .scl_i (scl_line), .sda_i (m_sda), .rd_ack_i (rd_ack), .ovf_clr_i (ovf_clr),
        .scl_hold_o (scl_hold), .rx_word_o (rx_word), .ready_o (ready),
        .overflow_o (overflow), .active_o (active), .idle_o (idle)
    );

    int checks = 0, errors = 0;
    bit auto_read = 1'b0;
    logic [WORD_W-1:0] exp_q[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwait(int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic logic [WORD_W-1:0] mk(logic [7:0] dv, logic st, logic rs, logic nk);
        return {nk, rs, st, dv};
    endfunction

    // Scoreboard monitor: reads a word whenever ready and compares in order.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_read && ready) begin
                if (exp_q.size() == 0) chk("R6 unexpected word", 32'(rx_word), 32'hFFFF);
                else chk("R2/R3/R4/R5 scoreboard word", 32'(rx_word), 32'(exp_q.pop_front()));
                rd_mon = 1'b1;
            end else begin
                rd_mon = 1'b0;
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; hwait(H);
        m_sda = 1'b0; hwait(H);
        m_scl = 1'b0; hwait(H);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; hwait(H);
        m_scl = 1'b1; while (!scl_line) @(posedge clk); hwait(H);
        m_sda = 1'b0; hwait(H);
        m_scl = 1'b0; hwait(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hwait(H);
        m_scl = 1'b1; while (!scl_line) @(posedge clk); hwait(H);
        m_sda = 1'b1; hwait(H);
    endtask

    task automatic send_bit(logic b);
        m_sda = b; hwait(H);
        m_scl = 1'b1; while (!scl_line) @(posedge clk); hwait(H);
        m_scl = 1'b0; hwait(H);
    endtask

    task automatic send_byte(logic [7:0] dv, logic nk, logic st, logic rs, bit push);
        if (push) exp_q.push_back(mk(dv, st, rs, nk));
        for (int i = 7; i >= 0; i--) send_bit(dv[i]);
        send_bit(nk);
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_up();
    end

    initial begin
        hwait(4);
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(ready), 0);
        chk("R1 overflow", 32'(overflow), 0);
        chk("R1 active", 32'(active), 0);
        chk("R1 idle", 32'(idle), 0);
        chk("R1 hold", 32'(scl_hold), 0);
        chk("R1 rx word", 32'(rx_word), 0);
        rst_n = 1'b1; mon_en = 1'b1;
        hwait(4);

        // Plain write with START, ACKs and a final NACK
        auto_read = 1'b1;
        bus_start();
        chk("R9 active after START", 32'(active), 1);
        chk("R9 idle cleared by START", 32'(idle), 0);
        send_byte(8'hA4, 1'b0, 1'b1, 1'b0, 1'b1);
        send_byte(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
        send_byte(8'hF0, 1'b1, 1'b0, 1'b0, 1'b1);
        bus_stop();
        hwait(4);
        chk("R9 active after STOP", 32'(active), 0);
        chk("R9 idle after STOP", 32'(idle), 1);
        chk("R4 all words delivered", 32'(exp_q.size()), 0);

        // Repeated START
        bus_start();
        send_byte(8'h51, 1'b0, 1'b1, 1'b0, 1'b1);
        bus_rstart();
        chk("R3 active through repeated START", 32'(active), 1);
        send_byte(8'h96, 1'b0, 1'b0, 1'b1, 1'b1);
        send_byte(8'h0F, 1'b1, 1'b0, 1'b0, 1'b1);
        bus_stop();
        hwait(4);
        chk("R3 all words delivered", 32'(exp_q.size()), 0);

        // Read strobe with ready low
        @(negedge clk); rd_force = 1'b1;
        @(negedge clk); rd_force = 1'b0;
        hwait(2); @(negedge clk);
        chk("R6 stray read keeps ready low", 32'(ready), 0);
        chk("R6 stray read keeps overflow low", 32'(overflow), 0);

        // Overflow without stretching
        auto_read = 1'b0;
        bus_start();
        send_byte(8'h11, 1'b0, 1'b1, 1'b0, 1'b1);
        send_byte(8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
        bus_stop();
        hwait(4); @(negedge clk);
        chk("R7 overflow set", 32'(overflow), 1);
        chk("R7 ready held", 32'(ready), 1);
        chk("R7 old word kept", 32'(rx_word), 32'h111);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        @(negedge clk);
        chk("R8 overflow cleared", 32'(overflow), 0);
        auto_read = 1'b1;
        hwait(8);
        chk("R7 only first word delivered", 32'(exp_q.size()), 0);

        // Stretching while the host is slow
        stretch_en = 1'b1; auto_read = 1'b0;
        fork
            begin
                bus_start();
                send_byte(8'h5A, 1'b0, 1'b1, 1'b0, 1'b1);
                send_byte(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);
                send_byte(8'h7E, 1'b1, 1'b0, 1'b0, 1'b1);
                bus_stop();
            end
            begin
                int n;
                n = 0;
                while (!scl_hold && n < 4000) begin @(posedge clk); n++; end
                @(negedge clk);
                chk("R10 SCL held", 32'(scl_hold), 1);
                hwait(200); @(negedge clk);
                chk("R10 line still low", 32'(scl_line), 0);
                chk("R10 no overflow while held", 32'(overflow), 0);
                auto_read = 1'b1;
            end
        join
        hwait(8); @(negedge clk);
        chk("R10 all held words delivered", 32'(exp_q.size()), 0);
        chk("R10 overflow stays clear", 32'(overflow), 0);
        chk("R10 hold released", 32'(scl_hold), 0);

        // Monitor disabled
        stretch_en = 1'b0; mon_en = 1'b0;
        bus_start();
        chk("R11 active stays low", 32'(active), 0);
        send_byte(8'h99, 1'b0, 1'b1, 1'b0, 1'b0);
        bus_stop();
        hwait(4); @(negedge clk);
        chk("R11 no word captured", 32'(ready), 0);
        chk("R11 no hold", 32'(scl_hold), 0);

        hwait(4);
        finish_up();
    end

endmodule